// File: doc/BRIEF.md
# Control-Register Transition Coverage Monitor

This block sits beside a simulation or emulation trace and watches records of retired instructions. Each record brings an instruction class code, a flag saying the instruction explicitly wrote a status register, an end-of-test marker, and a snapshot of the watched control and status fields. The fields are split into independent groups: for example, privilege and trap state in one group, and floating-point rounding mode and sticky exception flags in another. Fast-moving counters and scratch-like registers are left out of the snapshot, because they would change on every instruction.

For each record, the monitor visits the groups one at a time. For each group it compares the new value with the value left by the previous instruction of the same test. A real change becomes an edge keyed by group, instruction class, old value and new value. The monitor looks that edge up in a set-associative table that keeps full keys. An edge that is not in the table is inserted and marks the running test as worth keeping. When the test's last record has been handled, a one-cycle verdict reports whether the test reached any edge that had not been seen before in the session. The table is kept across tests and is cleared only by reset.

Top module: `csr_edge_monitor`

## Requirements
- R1: A record is accepted on a rising edge where `rec_valid_i` and `rec_ready_o` are both high. `rec_ready_o` is high only while idle. After an accept it stays low for exactly NUM_GRP cycles, one per group. The source holds `rec_valid_i` until the record is accepted.
- R2: Group g is bits [g*VAL_W +: VAL_W] of `rec_snap_i`. An edge exists for group g when its value differs from the value in the previous record of the same test. The first record of a test has no predecessor and yields no edge.
- R3: The instruction class is part of the key. The same old/new change under two different classes gives two entries. A repeat under the same class gives none.
- R4: A record with `rec_csr_wr_i` high yields no edge for any group. Its snapshot still becomes the reference for the next record.
- R5: Groups are independent. Identical class, old and new values seen in two different groups are two distinct entries.
- R6: When `grp_en_i[g]` is low, edges of group g are neither inserted nor counted toward the verdict.
- R7: The table starts empty after `rst_ni`, keeps its contents across tests, and is cleared only by `rst_ni`. A test that repeats only known edges is reported as discardable.
- R8: `verdict_valid_o` pulses for one cycle. It rises on the NUM_GRP-th rising edge after the edge that accepted a record with `rec_last_i` high. At that point `verdict_keep_o` is 1 exactly when the test produced at least one new edge.
- R9: The set index is bits [SET_W-1:0] of (old ^ new ^ class ^ group), each operand zero-extended to VAL_W. Each set has WAYS ways. A new edge that finds its set full is reported as new but is not stored, and `ovf_o` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous session reset |
| rec_valid_i | input | 1 | Record valid |
| rec_ready_o | output | 1 | Monitor can take a record |
| rec_cls_i | input | CLS_W | Instruction class code |
| rec_csr_wr_i | input | 1 | Instruction explicitly wrote a status register |
| rec_last_i | input | 1 | Last record of the current test |
| rec_snap_i | input | NUM_GRP*VAL_W | Group values after the instruction |
| grp_en_i | input | NUM_GRP | Per-group contribution enable |
| verdict_valid_o | output | 1 | One-cycle verdict strobe |
| verdict_keep_o | output | 1 | Test reached a new edge |
| ovf_o | output | 1 | Sticky: a new edge found its set full |

## Verification
The assertions assume the record source keeps `rec_valid_i` asserted until the record is taken. They also assume `grp_en_i` is stable while a record is being scanned. The bench raises a record only at a falling edge, holds it until an edge sees `rec_ready_o` high, and changes the enable mask only between tests. The bench chooses values and classes with the set hash in mind. This lets it steer five new edges into one empty set, so that the overflow case and the persistence of earlier entries both give outcomes it can predict.

// File: rtl/csr_mon_pkg.sv
package csr_mon_pkg;
  typedef enum logic {ST_IDLE, ST_SCAN} mon_state_e;
endpackage

// File: rtl/csr_snap_track.sv
module csr_snap_track #(
  parameter int NUM_GRP = 2,
  parameter int VAL_W   = 8,
  parameter int GRP_W   = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     last_i,
  input  logic [NUM_GRP*VAL_W-1:0] snap_i,
  input  logic [GRP_W-1:0]         sel_i,
  output logic [VAL_W-1:0]         old_o,
  output logic [VAL_W-1:0]         new_o,
  output logic                     chg_o
);
  logic [NUM_GRP-1:0][VAL_W-1:0] prev_q, old_q, cur_q;
  logic have_prev_q, have_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g] <= '0;
        old_q[g]  <= '0;
        cur_q[g]  <= '0;
      end else if (load_i) begin
        old_q[g]  <= prev_q[g];
        cur_q[g]  <= snap_i[g*VAL_W +: VAL_W];
        prev_q[g] <= snap_i[g*VAL_W +: VAL_W];
      end
    end
  end

  // a test boundary drops the reference
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      have_q      <= 1'b0;
    end else if (load_i) begin
      have_q      <= have_prev_q;
      have_prev_q <= !last_i;
    end
  end

  assign old_o = old_q[sel_i];
  assign new_o = cur_q[sel_i];
  assign chg_o = have_q && (old_q[sel_i] != cur_q[sel_i]);
endmodule

// File: rtl/csr_edge_map.sv
module csr_edge_map #(
  parameter int GRP_W = 1,
  parameter int CLS_W = 4,
  parameter int VAL_W = 8,
  parameter int SETS  = 8,
  parameter int WAYS  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             look_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [VAL_W-1:0] old_i,
  input  logic [VAL_W-1:0] new_i,
  output logic             new_o,
  output logic             full_o
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int ENT   = SETS * WAYS;
  localparam int IDX_W = SET_W + WAY_W;
  localparam int KEY_W = GRP_W + CLS_W + 2 * VAL_W;

  logic [ENT-1:0]   vld_q;
  logic [KEY_W-1:0] key_q [ENT];
  logic [KEY_W-1:0] key;
  logic [VAL_W-1:0] mix;
  logic [SET_W-1:0] set_idx;
  logic [WAY_W-1:0] free_way;
  logic [IDX_W-1:0] ins_idx;
  logic             hit, free_found, do_ins;

  assign key     = {grp_i, cls_i, old_i, new_i};
  assign mix     = old_i ^ new_i ^ VAL_W'(cls_i) ^ VAL_W'(grp_i);
  assign set_idx = mix[SET_W-1:0];

  always_comb begin
    hit        = 1'b0;
    free_found = 1'b0;
    free_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[{set_idx, WAY_W'(w)}] && key_q[{set_idx, WAY_W'(w)}] == key) hit = 1'b1;
      if (!vld_q[{set_idx, WAY_W'(w)}] && !free_found) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
  end

  assign ins_idx = {set_idx, free_way};
  assign do_ins  = look_i && !hit && free_found;
  assign new_o   = look_i && !hit;
  assign full_o  = look_i && !hit && !free_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vld_q          <= '0;
    else if (do_ins) vld_q[ins_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (do_ins) key_q[ins_idx] <= key;
  end

  // R7: entries are never dropped inside a session
  p_vld_monotone_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q & $past(vld_q)) == $past(vld_q));

  // R9: an insertion grows occupancy by exactly one
  p_fill_grows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_o && !full_o) |=> $countones(vld_q) == $past($countones(vld_q)) + 1);
endmodule

// File: rtl/csr_edge_monitor.sv
module csr_edge_monitor
  import csr_mon_pkg::*;
#(
  parameter int NUM_GRP = 2,
  parameter int VAL_W   = 8,
  parameter int CLS_W   = 4,
  parameter int SETS    = 8,
  parameter int WAYS    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rec_valid_i,
  output logic                     rec_ready_o,
  input  logic [CLS_W-1:0]         rec_cls_i,
  input  logic                     rec_csr_wr_i,
  input  logic                     rec_last_i,
  input  logic [NUM_GRP*VAL_W-1:0] rec_snap_i,
  input  logic [NUM_GRP-1:0]       grp_en_i,
  output logic                     verdict_valid_o,
  output logic                     verdict_keep_o,
  output logic                     ovf_o
);
  localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  mon_state_e       st_q;
  logic [GRP_W-1:0] idx_q;
  logic [CLS_W-1:0] cls_q;
  logic             wr_q, last_q, acc_q;
  logic             accept, look, chg, map_new, map_full, new_now, at_end;
  logic [VAL_W-1:0] old_v, new_v;

  assign rec_ready_o = (st_q == ST_IDLE);
  assign accept      = rec_valid_i && rec_ready_o;

  csr_snap_track #(.NUM_GRP(NUM_GRP), .VAL_W(VAL_W), .GRP_W(GRP_W)) u_track (
    .clk_i, .rst_ni,
    .load_i (accept),
    .last_i (rec_last_i),
    .snap_i (rec_snap_i),
    .sel_i  (idx_q),
    .old_o  (old_v),
    .new_o  (new_v),
    .chg_o  (chg)
  );

  // explicit status writes and masked groups never reach the map
  assign look    = (st_q == ST_SCAN) && chg && !wr_q && grp_en_i[idx_q];
  assign new_now = map_new;
  assign at_end  = (idx_q == GRP_W'(NUM_GRP - 1));

  csr_edge_map #(.GRP_W(GRP_W), .CLS_W(CLS_W), .VAL_W(VAL_W), .SETS(SETS), .WAYS(WAYS)) u_map (
    .clk_i, .rst_ni,
    .look_i (look),
    .grp_i  (idx_q),
    .cls_i  (cls_q),
    .old_i  (old_v),
    .new_i  (new_v),
    .new_o  (map_new),
    .full_o (map_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= ST_IDLE;
      idx_q           <= '0;
      cls_q           <= '0;
      wr_q            <= 1'b0;
      last_q          <= 1'b0;
      acc_q           <= 1'b0;
      verdict_valid_o <= 1'b0;
      verdict_keep_o  <= 1'b0;
      ovf_o           <= 1'b0;
    end else begin
      verdict_valid_o <= 1'b0;
      if (map_full) ovf_o <= 1'b1;
      if (accept) begin
        st_q   <= ST_SCAN;
        idx_q  <= '0;
        cls_q  <= rec_cls_i;
        wr_q   <= rec_csr_wr_i;
        last_q <= rec_last_i;
      end else if (st_q == ST_SCAN) begin
        if (at_end) begin
          st_q <= ST_IDLE;
          if (last_q) begin
            verdict_valid_o <= 1'b1;
            verdict_keep_o  <= acc_q | new_now;
            acc_q           <= 1'b0;
          end else begin
            acc_q <= acc_q | new_now;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
          acc_q <= acc_q | new_now;
        end
      end
    end
  end

  // R1: source holds a pending record
  p_rec_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && !rec_ready_o) |=> rec_valid_i);

  // R8: verdict is a single-cycle strobe
  p_verdict_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |=> !verdict_valid_o);

  // R9: overflow stays set for the session
  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R1: no acceptance while a record is being scanned
  p_busy_no_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !rec_ready_o);
endmodule

// File: tb/csr_edge_monitor_tb_top.sv
module csr_edge_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [3:0]  rec_cls = '0;
  logic        rec_wr = 1'b0;
  logic        rec_last = 1'b0;
  logic [15:0] rec_snap = '0;
  logic [1:0]  grp_en = 2'b11;
  logic        verdict_valid, verdict_keep, ovf;

  int n_chk = 0;
  int n_fail = 0;
  int vcnt = 0;
  logic vkeep = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csr_edge_monitor dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rec_valid_i(rec_valid), .rec_ready_o(rec_ready),
    .rec_cls_i(rec_cls), .rec_csr_wr_i(rec_wr), .rec_last_i(rec_last),
    .rec_snap_i(rec_snap), .grp_en_i(grp_en),
    .verdict_valid_o(verdict_valid), .verdict_keep_o(verdict_keep), .ovf_o(ovf)
  );

  always @(negedge clk) if (verdict_valid) begin
    vcnt  <= vcnt + 1;
    vkeep <= verdict_keep;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] cls, input logic wr, input logic [7:0] g0,
                      input logic [7:0] g1, input logic last);
    @(negedge clk);
    rec_valid = 1'b1; rec_cls = cls; rec_wr = wr; rec_last = last; rec_snap = {g1, g0};
    while (!rec_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic expect_verdict(input string req, input int exp_keep);
    int start;
    start = vcnt;
    for (int i = 0; i < 10 && vcnt == start; i++) @(negedge clk);
    check({req, " verdict seen"}, vcnt - start, 1);
    check({req, " keep"}, int'(vkeep), exp_keep);
  endtask

  task automatic t_reset;
    check("R8 reset verdict", int'(verdict_valid), 0);
    check("R1 reset ready", int'(rec_ready), 1);
    check("R9 reset ovf", int'(ovf), 0);
  endtask

  task automatic t_basic;  // R2 and R7
    send(4'd1, 1'b0, 8'h00, 8'h00, 1'b0);
    send(4'd2, 1'b0, 8'h01, 8'h00, 1'b1);
    expect_verdict("R2 new edge", 1);
    send(4'd1, 1'b0, 8'h00, 8'h00, 1'b0);
    send(4'd2, 1'b0, 8'h01, 8'h00, 1'b1);
    expect_verdict("R7 repeat discard", 0);
  endtask

  task automatic t_class;  // R3
    send(4'd1, 1'b0, 8'h00, 8'h00, 1'b0);
    send(4'd3, 1'b0, 8'h01, 8'h00, 1'b1);
    expect_verdict("R3 other class distinct", 1);
  endtask

  task automatic t_filter;  // R4
    send(4'd1, 1'b0, 8'h00, 8'h00, 1'b0);
    send(4'd5, 1'b1, 8'h40, 8'h00, 1'b1);
    expect_verdict("R4 write filtered", 0);
    send(4'd1, 1'b0, 8'h00, 8'h00, 1'b0);
    send(4'd5, 1'b1, 8'h40, 8'h00, 1'b0);
    send(4'd6, 1'b0, 8'h40, 8'h00, 1'b1);
    expect_verdict("R4 write snapshot is reference", 0);
    send(4'd1, 1'b0, 8'h40, 8'h00, 1'b0);
    send(4'd6, 1'b0, 8'h41, 8'h00, 1'b1);
    expect_verdict("R4 later real change", 1);
  endtask

  task automatic t_group;  // R5
    send(4'd1, 1'b0, 8'h00, 8'h00, 1'b0);
    send(4'd2, 1'b0, 8'h00, 8'h01, 1'b1);
    expect_verdict("R5 group independent", 1);
  endtask

  task automatic t_mask;  // R6
    grp_en = 2'b01;
    send(4'd1, 1'b0, 8'h00, 8'h05, 1'b0);
    send(4'd4, 1'b0, 8'h00, 8'h07, 1'b1);
    expect_verdict("R6 masked group", 0);
    grp_en = 2'b11;
    send(4'd1, 1'b0, 8'h00, 8'h05, 1'b0);
    send(4'd4, 1'b0, 8'h00, 8'h07, 1'b1);
    expect_verdict("R6 masked edge not stored", 1);
  endtask

  task automatic t_first;  // R2
    send(4'd7, 1'b0, 8'h99, 8'h33, 1'b1);
    expect_verdict("R2 first record no edge", 0);
  endtask

  task automatic t_timing;  // R8 and R1
    @(negedge clk);
    rec_valid = 1'b1; rec_cls = 4'd7; rec_wr = 1'b0; rec_last = 1'b1; rec_snap = 16'h3399;
    check("R1 ready before accept", int'(rec_ready), 1);
    @(posedge clk);
    @(negedge clk);
    rec_valid = 1'b0;
    check("R1 busy cycle 1", int'(rec_ready), 0);
    check("R8 no early verdict 1", int'(verdict_valid), 0);
    @(negedge clk);
    check("R1 busy cycle 2", int'(rec_ready), 0);
    check("R8 no early verdict 2", int'(verdict_valid), 0);
    @(negedge clk);
    check("R1 ready again", int'(rec_ready), 1);
    check("R8 verdict cycle", int'(verdict_valid), 1);
    @(negedge clk);
    check("R8 single pulse", int'(verdict_valid), 0);
  endtask

  task automatic t_overflow;  // R9: all land in set 0
    logic [7:0] nv [5] = '{8'h28, 8'h30, 8'h38, 8'h48, 8'h50};
    for (int i = 0; i < 5; i++) begin
      send(4'd0, 1'b0, 8'h20, 8'h00, 1'b0);
      send(4'd8, 1'b0, nv[i], 8'h00, 1'b1);
      expect_verdict("R9 fill set", 1);
      check("R9 ovf level", int'(ovf), (i == 4) ? 1 : 0);
    end
    send(4'd0, 1'b0, 8'h20, 8'h00, 1'b0);
    send(4'd8, 1'b0, 8'h50, 8'h00, 1'b1);
    expect_verdict("R9 overflowed edge not stored", 1);
    send(4'd0, 1'b0, 8'h20, 8'h00, 1'b0);
    send(4'd8, 1'b0, 8'h28, 8'h00, 1'b1);
    expect_verdict("R9 stored way kept", 0);
    check("R9 ovf sticky", int'(ovf), 1);
  endtask

  task automatic t_session_reset;  // R7
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R9 ovf cleared by reset", int'(ovf), 0);
    send(4'd1, 1'b0, 8'h00, 8'h00, 1'b0);
    send(4'd2, 1'b0, 8'h01, 8'h00, 1'b1);
    expect_verdict("R7 map cleared by reset", 1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_class();
    t_filter();
    t_group();
    t_mask();
    t_first();
    t_timing();
    t_overflow();
    t_session_reset();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule